// File: doc/BRIEF.md
# Scan Chain Array with Switchable Frozen Group

This block is a full-scan register array built as several scan chains of equal length. Each cell is a mux-D flip-flop: with scan-enable high it takes the bit from its serial neighbour, and with scan-enable low it captures a functional next-state value. That value comes from a small combinational test network inside the block. The network mixes the array's own state with a parallel stimulus word.

The chains fall into two fixed groups. The low-numbered chains are always clocked. The highest-numbered chains form a group that a tester can freeze with a dedicated input. While frozen, those cells neither shift nor capture. They keep their contents and keep driving them into the test network as a constant stimulus. Fewer cells toggle, so switching activity during test drops.

The freeze request passes through a register, and that register acts as a clock enable on the frozen group. A change on the input is therefore seen on one edge and acts from the following edge. A synchronous reset clears every cell and the freeze register.

Top module: `scan_partition_top`

## Requirements
- R1: Chains 0 to NUM_CHAINS-NUM_FROZEN-1 (the always-on group) update on every clock edge, whatever the state of the freeze input.
- R2: While the registered freeze flag is set, every cell of the frozen group keeps its value across an edge, in shift mode and in capture mode alike.
- R3: The freeze input is sampled on a clock edge and acts from the next edge on. The edge that samples a new value still follows the old one, for both setting and releasing.
- R4: With scan_en high, cell position 0 of chain c loads scan_in[c], position p loads position p-1 of the same chain, and scan_out[c] is position CHAIN_LEN-1 of chain c.
- R5: With scan_en low, the cell with flat index i = c*CHAIN_LEN+p loads state[(i+1) mod TOTAL] XOR cap_word[i].
- R6: The held contents of a frozen chain keep feeding the test network, so an always-on cell whose next state depends on a frozen cell captures that held value.
- R7: A synchronous reset (rst high at an edge) clears all cells of both groups and the freeze register, even while freeze is high.
- R8: The frozen group is the NUM_FROZEN highest-numbered chains. The chain just below it is never frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all cells |
| rst | input | 1 | Synchronous reset, active high |
| scan_en | input | 1 | 1 = shift, 0 = capture |
| freeze | input | 1 | Request to stop clocking the frozen group |
| scan_in | input | NUM_CHAINS | Serial input bit of each chain |
| cap_word | input | NUM_CHAINS*CHAIN_LEN | Parallel stimulus into the test network |
| scan_out | output | NUM_CHAINS | Serial output bit (last cell) of each chain |

## Verification
A wrong cell value in this block is not seen at once. It reaches scan_out[c] only after the remaining positions of its chain have been shifted, which takes up to CHAIN_LEN edges. A capture can also pass it to a neighbouring cell and surface later. The bench therefore runs a model of every cell alongside the design and compares all serial outputs after every edge. A frozen group that leaks one edge early or late leaves a one-position shift in the next unload of those chains.

// File: rtl/scan_part_pkg.sv
package scan_part_pkg;

   typedef enum logic {
      MODE_CAPTURE = 1'b0,
      MODE_SHIFT   = 1'b1
   } scan_mode_e;

   function automatic int unsigned flat_base(input int unsigned chain,
                                             input int unsigned len);
      return chain * len;
   endfunction

endpackage

// File: rtl/scan_freeze_ctrl.sv
module scan_freeze_ctrl #(
   parameter int unsigned HAS_FROZEN = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic freeze,
   output logic frz_q
);

   generate
      if (HAS_FROZEN != 0) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) frz_q <= 1'b0;
            else     frz_q <= freeze;
         end
      end else begin : g_none
         assign frz_q = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/scan_test_net.sv
module scan_test_net #(
   parameter int unsigned TOTAL = 32
) (
   input  logic [TOTAL-1:0] state,
   input  logic [TOTAL-1:0] cap_word,
   output logic [TOTAL-1:0] nxt
);

   generate
      if (TOTAL == 1) begin : g_single
         assign nxt = state ^ cap_word;
      end else begin : g_rot
         assign nxt = {state[0], state[TOTAL-1:1]} ^ cap_word;
      end
   endgenerate

endmodule

// File: rtl/scan_chain.sv
module scan_chain
   import scan_part_pkg::*;
#(
   parameter int unsigned LEN = 4
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           en,
   input  scan_mode_e     mode,
   input  logic           sin,
   input  logic [LEN-1:0] cap_d,
   output logic [LEN-1:0] q
);

   logic [LEN-1:0] shift_d;

   generate
      if (LEN == 1) begin : g_one
         assign shift_d = sin;
      end else begin : g_many
         assign shift_d = {q[LEN-2:0], sin};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (en)
         q <= (mode == MODE_SHIFT) ? shift_d : cap_d;
   end

endmodule

// File: rtl/scan_partition_top.sv
module scan_partition_top
   import scan_part_pkg::*;
#(
   parameter int unsigned NUM_CHAINS = 8,
   parameter int unsigned CHAIN_LEN  = 4,
   parameter int unsigned NUM_FROZEN = 4,
   localparam int unsigned TOTAL     = NUM_CHAINS * CHAIN_LEN,
   localparam int unsigned NUM_LIVE  = NUM_CHAINS - NUM_FROZEN
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  scan_en,
   input  logic                  freeze,
   input  logic [NUM_CHAINS-1:0] scan_in,
   input  logic [TOTAL-1:0]      cap_word,
   output logic [NUM_CHAINS-1:0] scan_out
);

   if (NUM_CHAINS < 1) begin : g_chk_chains
      $error("NUM_CHAINS must be at least 1");
   end
   if (CHAIN_LEN < 1) begin : g_chk_len
      $error("CHAIN_LEN must be at least 1");
   end
   if (NUM_FROZEN >= NUM_CHAINS) begin : g_chk_frozen
      $error("NUM_FROZEN must leave at least one always-on chain");
   end

   logic [TOTAL-1:0] cells;
   logic [TOTAL-1:0] nxt;
   logic             frz_q;
   scan_mode_e       mode;

   assign mode = scan_en ? MODE_SHIFT : MODE_CAPTURE;

   scan_freeze_ctrl #(
      .HAS_FROZEN((NUM_FROZEN > 0) ? 1 : 0)
   ) u_frz (
      .clk    (clk),
      .rst    (rst),
      .freeze (freeze),
      .frz_q  (frz_q)
   );

   scan_test_net #(
      .TOTAL(TOTAL)
   ) u_net (
      .state    (cells),
      .cap_word (cap_word),
      .nxt      (nxt)
   );

   generate
      for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
         localparam int unsigned BASE = flat_base(c, CHAIN_LEN);
         logic en;
         if (c < NUM_LIVE) begin : g_live
            assign en = 1'b1;
         end else begin : g_frozen
            assign en = ~frz_q;
         end
         scan_chain #(
            .LEN(CHAIN_LEN)
         ) u_chain (
            .clk   (clk),
            .rst   (rst),
            .en    (en),
            .mode  (mode),
            .sin   (scan_in[c]),
            .cap_d (nxt[BASE +: CHAIN_LEN]),
            .q     (cells[BASE +: CHAIN_LEN])
         );
         assign scan_out[c] = cells[BASE + CHAIN_LEN - 1];
      end
   endgenerate

endmodule

// File: rtl/scan_partition_chk.sv
module scan_partition_chk #(
   parameter int unsigned NUM_CHAINS = 8,
   parameter int unsigned CHAIN_LEN  = 4,
   parameter int unsigned NUM_FROZEN = 4,
   localparam int unsigned TOTAL     = NUM_CHAINS * CHAIN_LEN,
   localparam int unsigned LIVE_CELLS = (NUM_CHAINS - NUM_FROZEN) * CHAIN_LEN
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  scan_en,
   input logic                  freeze,
   input logic [NUM_CHAINS-1:0] scan_in,
   input logic [TOTAL-1:0]      cells,
   input logic [TOTAL-1:0]      nxt,
   input logic                  frz_q
);

   logic [TOTAL-1:0] frozen_mask;
   assign frozen_mask = ~((TOTAL'(1) << LIVE_CELLS) - TOTAL'(1));

   // R2: frozen group stable while the registered flag is set
   p_frozen_hold_r2: assert property (@(posedge clk) disable iff (rst)
      frz_q |=> $stable(cells & frozen_mask));

   // R3: freeze input takes hold one edge later
   p_freeze_latency_r3: assert property (@(posedge clk) disable iff (rst)
      freeze |=> frz_q);

   // R1, R4: first cell of chain 0 loads scan_in[0] when shifting, frozen or not
   p_live_shift_r1: assert property (@(posedge clk) disable iff (rst)
      scan_en |=> (cells[0] == $past(scan_in[0])));

   // R5: first cell of chain 0 captures the test network output
   p_live_capture_r5: assert property (@(posedge clk) disable iff (rst)
      !scan_en |=> (cells[0] == $past(nxt[0])));

   // R8: first frozen chain shifts when not frozen
   p_frozen_runs_r8: assert property (@(posedge clk) disable iff (rst)
      (!frz_q && scan_en) |=> (cells[LIVE_CELLS] == $past(scan_in[NUM_CHAINS-NUM_FROZEN])));

   // R7: reset clears everything
   p_reset_clear_r7: assert property (@(posedge clk)
      rst |=> (cells == '0 && !frz_q));

endmodule

bind scan_partition_top scan_partition_chk #(
   .NUM_CHAINS (NUM_CHAINS),
   .CHAIN_LEN  (CHAIN_LEN),
   .NUM_FROZEN (NUM_FROZEN)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .scan_en (scan_en),
   .freeze  (freeze),
   .scan_in (scan_in),
   .cells   (cells),
   .nxt     (nxt),
   .frz_q   (frz_q)
);

// File: tb/scan_partition_top_test.sv
`timescale 1ns/1ps
module scan_partition_top_test;

   localparam int unsigned NC = 8;
   localparam int unsigned LEN = 4;
   localparam int unsigned NF = 4;
   localparam int unsigned T = NC * LEN;

   typedef struct {
      logic [NC-1:0] exp;
      string         tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          scan_en = 1'b0;
   logic          freeze = 1'b0;
   logic [NC-1:0] scan_in = '0;
   logic [T-1:0]  cap_word = '0;
   logic [NC-1:0] scan_out;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   item_t sb[$];

   logic [T-1:0] m = '0;
   logic         mfrz = 1'b0;

   always #4 clk = ~clk;

   scan_partition_top #(
      .NUM_CHAINS(NC), .CHAIN_LEN(LEN), .NUM_FROZEN(NF)
   ) uut (
      .clk(clk), .rst(rst), .scan_en(scan_en), .freeze(freeze),
      .scan_in(scan_in), .cap_word(cap_word), .scan_out(scan_out)
   );

   function automatic logic [NC-1:0] outs(input logic [T-1:0] s);
      logic [NC-1:0] o;
      for (int c = 0; c < NC; c++) o[c] = s[c*LEN + LEN - 1];
      return o;
   endfunction

   // Driver: apply inputs, advance the model per the requirements, queue the expected outputs
   task automatic step(input logic r, input logic se, input logic fz,
                       input logic [NC-1:0] si, input logic [T-1:0] cw,
                       input string tag);
      logic [T-1:0] n;
      @(negedge clk);
      rst = r; scan_en = se; freeze = fz; scan_in = si; cap_word = cw;
      @(posedge clk);
      if (r) begin
         n = '0;
         mfrz = 1'b0;
      end else begin
         for (int i = 0; i < T; i++) begin
            int c = i / LEN;
            int p = i % LEN;
            bit en = (c < NC - NF) || !mfrz;
            if (!en) n[i] = m[i];
            else if (se) n[i] = (p == 0) ? si[c] : m[i-1];
            else n[i] = m[(i+1) % T] ^ cw[i];
         end
         mfrz = fz;
      end
      m = n;
      sb.push_back('{exp: outs(m), tag: tag});
   endtask

   // Monitor: compare between edges
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         checks++;
         if (scan_out !== it.exp) begin
            fails++;
            $display("FAIL %s: scan_out=%h expected %h", it.tag, scan_out, it.exp);
         end
      end
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      // R7: reset state
      step(1, 0, 0, '0, '0, "R7");
      step(1, 0, 0, '0, '0, "R7");
      // R4: fill by shifting, unfrozen
      for (int k = 0; k < 6; k++) step(0, 1, 0, NC'(k*37 + 5), '0, "R4");
      // R5: capture
      step(0, 0, 0, '0, 32'hA5C3_0F96, "R5");
      for (int k = 0; k < 4; k++) step(0, 1, 0, NC'(k*11 + 3), '0, "R4");
      step(0, 0, 0, '0, 32'h1234_9ABC, "R5");
      // R3: freeze sampled; this edge still moves the frozen group
      step(0, 1, 1, 8'hFF, '0, "R3");
      // R2 / R1 / R8: frozen group holds, always-on group shifts
      for (int k = 0; k < 3; k++) step(0, 1, 1, NC'(k*53 + 9), '0, "R2");
      step(0, 1, 1, 8'h18, '0, "R8");
      step(0, 1, 1, 8'h0F, '0, "R1");
      // R6 / R2: capture while frozen, always-on last cell reads a held frozen cell
      step(0, 0, 1, '0, 32'h0F0F_F0F0, "R6");
      step(0, 0, 1, '0, 32'h5555_AAAA, "R2");
      for (int k = 0; k < 4; k++) step(0, 1, 1, NC'(k*29 + 1), '0, "R1");
      // R3: release sampled; frozen group still holds for this edge
      step(0, 1, 0, 8'hAA, '0, "R3");
      for (int k = 0; k < 5; k++) step(0, 1, 0, NC'(k*71 + 13), '0, "R8");
      step(0, 0, 0, '0, 32'hDEAD_BEEF, "R5");
      for (int k = 0; k < 4; k++) step(0, 1, 0, NC'(k), '0, "R4");
      // R7: load ones, freeze, reset while freeze stays high
      for (int k = 0; k < 4; k++) step(0, 1, 0, 8'hFF, '0, "R4");
      step(0, 1, 1, 8'hFF, '0, "R3");
      step(1, 1, 1, 8'hFF, '0, "R7");
      for (int k = 0; k < 4; k++) step(0, 1, 0, '0, '0, "R7");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule